// File: doc/BRIEF.md
# Transmit End-of-Packet Detector with SE0 Glitch Filter

This block watches the two-bit line-state bus from a USB 2.0 transceiver while the controller sends at full or low speed. It decides when the transceiver has finished sending a packet, which it sees as the SE0 part of the end-of-packet pattern. It then pulses a transmit-complete output, and the controller uses that pulse to start its next packet. A D+/D- skew of a few nanoseconds can make a false one-sample SE0 appear on the line state in the middle of a packet. An optional filter handles this by requiring SE0 on several consecutive clock edges before it accepts an end of packet.

The filter is switched by one enable input, and it only acts in certain mode and speed combinations. In host mode it covers both full-speed and low-speed transmissions. In device mode it covers only full-speed transmission of a link-power-management handshake. Every other transmission uses unfiltered detection. When a short SE0 run is thrown away by the filter, a separate pulse reports it.

Top module: `linestate_eop_detector`

## Requirements
- R1: With the filter active, an SE0 run shorter than MIN_RUN (default 2) consecutive samples, ended by a non-SE0 sample, produces no end-of-packet pulse.
- R2: With the filter active, SE0 sampled on MIN_RUN consecutive edges while transmitting raises `eop_o` in the cycle after the edge that samples the MIN_RUN-th SE0.
- R3: With `filt_en_i` low, one SE0 sample while transmitting raises `eop_o` in the next cycle.
- R4: In host mode (`host_mode_i`=1), the filter is active for both `low_speed_i`=0 and `low_speed_i`=1.
- R5: In device mode, the filter is active only when `low_speed_i`=0 and `lpm_hs_i`=1. All other device transmissions use single-sample detection.
- R6: Line-state encoding: 2'b00 is SE0, 2'b01 and 2'b10 are J/K (which one depends on speed), and 2'b11 is SE1. Only 2'b00 counts toward an end of packet. Any other code, SE1 included, ends an SE0 run.
- R7: While `tx_active_i` is low, both outputs stay low. A low sample of `tx_active_i` also clears any SE0 run in progress.
- R8: `eop_o` is a one-cycle pulse and fires at most once per packet. It can fire again only after `tx_active_i` has been sampled low.
- R9: With the filter active, before the end of packet in a packet, an SE0 run shorter than MIN_RUN that is ended by a non-SE0 sample raises `glitch_o` for one cycle, in the cycle after that non-SE0 sample.
- R10: Asynchronous active-low reset clears both outputs at once and leaves the detector disarmed. Detection starts only after `tx_active_i` has been sampled low once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transceiver-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| linestate_i | input | 2 | Line state from the transceiver |
| tx_active_i | input | 1 | Controller is transmitting a packet |
| low_speed_i | input | 1 | 1 = low speed, 0 = full speed |
| host_mode_i | input | 1 | 1 = host role, 0 = device role |
| lpm_hs_i | input | 1 | Current transmission is a link-power-management handshake |
| filt_en_i | input | 1 | Enable for the SE0 glitch filter |
| eop_o | output | 1 | End-of-packet detected, one-cycle pulse |
| glitch_o | output | 1 | Short SE0 run rejected, one-cycle pulse |

## Verification
Both outputs are registered, so each result is due exactly one cycle after the clock edge that samples its deciding line-state value. An end of packet appears one cycle after the last SE0 sample it needs. A glitch report appears one cycle after the non-SE0 sample that cuts a short run. The bench drives inputs on the falling edge. A behavioural reference model updates on the rising edge from the same sampled inputs, and both outputs are compared with that model at every falling edge, so every expectation is checked in its exact cycle. Per-packet counts of pulses are then checked against values worked out by hand for each mode, speed and sequence.

// File: rtl/lsed_pkg.sv
package lsed_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_ST1 = 2'b01,
    LS_ST2 = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  function automatic logic is_se0(input logic [1:0] ls);
    return ls == LS_SE0;
  endfunction
endpackage

// File: rtl/lsed_mode_sel.sv
module lsed_mode_sel (
  input  logic filt_en_i,
  input  logic host_mode_i,
  input  logic low_speed_i,
  input  logic lpm_hs_i,
  output logic filt_act_o
);
  logic dev_ok;
  // device role: only full-speed LPM handshake is filtered
  assign dev_ok     = !low_speed_i && lpm_hs_i;
  assign filt_act_o = filt_en_i && (host_mode_i || dev_ok);
endmodule

// File: rtl/lsed_run_ctr.sv
module lsed_run_ctr #(
  parameter int unsigned MIN_RUN = 2,
  localparam int unsigned RUN_W = $clog2(MIN_RUN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_active_i,
  input  logic             se0_i,
  output logic [RUN_W-1:0] run_o
);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(MIN_RUN);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (!tx_active_i || !se0_i) begin
      run_q <= '0;
    end else if (run_q != RUN_SAT) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/lsed_eop_gen.sv
module lsed_eop_gen #(
  parameter int unsigned MIN_RUN = 2,
  localparam int unsigned RUN_W = $clog2(MIN_RUN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_active_i,
  input  logic             se0_i,
  input  logic             filt_act_i,
  input  logic [RUN_W-1:0] run_i,
  output logic             eop_o,
  output logic             glitch_o
);
  logic [RUN_W:0] need, run_inc;
  logic           armed_q, eop_q, glitch_q;
  logic           eop_d, glitch_d;

  assign need    = filt_act_i ? (RUN_W+1)'(MIN_RUN) : (RUN_W+1)'(1);
  assign run_inc = {1'b0, run_i} + 1'b1;

  assign eop_d    = tx_active_i && armed_q && se0_i && (run_inc >= need);
  assign glitch_d = tx_active_i && armed_q && !se0_i && filt_act_i &&
                    (run_i != '0) && ({1'b0, run_i} < need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      eop_q    <= 1'b0;
      glitch_q <= 1'b0;
    end else begin
      eop_q    <= eop_d;
      glitch_q <= glitch_d;
      // re-arm on any idle sample, disarm once the packet has ended
      if (!tx_active_i) armed_q <= 1'b1;
      else if (eop_d)   armed_q <= 1'b0;
    end
  end

  assign eop_o    = eop_q;
  assign glitch_o = glitch_q;
endmodule

// File: rtl/linestate_eop_detector.sv
module linestate_eop_detector #(
  parameter int unsigned MIN_RUN = 2,
  localparam int unsigned RUN_W = $clog2(MIN_RUN + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] linestate_i,
  input  logic       tx_active_i,
  input  logic       low_speed_i,
  input  logic       host_mode_i,
  input  logic       lpm_hs_i,
  input  logic       filt_en_i,
  output logic       eop_o,
  output logic       glitch_o
);
  import lsed_pkg::*;

  logic             se0;
  logic             filt_act;
  logic [RUN_W-1:0] run;

  assign se0 = is_se0(linestate_i);

  lsed_mode_sel u_mode (
    .filt_en_i   (filt_en_i),
    .host_mode_i (host_mode_i),
    .low_speed_i (low_speed_i),
    .lpm_hs_i    (lpm_hs_i),
    .filt_act_o  (filt_act)
  );

  lsed_run_ctr #(.MIN_RUN(MIN_RUN)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_active_i (tx_active_i),
    .se0_i       (se0),
    .run_o       (run)
  );

  lsed_eop_gen #(.MIN_RUN(MIN_RUN)) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_active_i (tx_active_i),
    .se0_i       (se0),
    .filt_act_i  (filt_act),
    .run_i       (run),
    .eop_o       (eop_o),
    .glitch_o    (glitch_o)
  );
endmodule

// File: rtl/lsed_checker.sv
module lsed_checker #(
  parameter int unsigned MIN_RUN = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] linestate_i,
  input logic       tx_active_i,
  input logic       low_speed_i,
  input logic       host_mode_i,
  input logic       lpm_hs_i,
  input logic       filt_en_i,
  input logic       eop_o,
  input logic       glitch_o
);
  logic filt_spec;
  logic fired_q;

  assign filt_spec = filt_en_i && (host_mode_i || (!low_speed_i && lpm_hs_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           fired_q <= 1'b0;
    else if (!tx_active_i) fired_q <= 1'b0;
    else if (eop_o)        fired_q <= 1'b1;
  end

  AST_EOP_AFTER_SE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> ($past(linestate_i) == 2'b00) && $past(tx_active_i)) else $error("eop"); // R3

  AST_EOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o); // R8

  AST_EOP_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> !fired_q); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_active_i) |-> !eop_o && !glitch_o); // R7

  AST_GLITCH_FILTERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_o |-> $past(filt_spec) && ($past(linestate_i) != 2'b00)); // R9

  AST_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eop_o && glitch_o)); // R9

  generate
    if (MIN_RUN >= 2) begin : g_filt
      AST_FILT_TWO_SE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eop_o && $past(filt_spec)) |-> ($past(linestate_i, 2) == 2'b00) && $past(tx_active_i, 2)); // R2
    end
  endgenerate
endmodule

bind linestate_eop_detector lsed_checker #(.MIN_RUN(MIN_RUN)) u_lsed_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .linestate_i (linestate_i),
  .tx_active_i (tx_active_i),
  .low_speed_i (low_speed_i),
  .host_mode_i (host_mode_i),
  .lpm_hs_i    (lpm_hs_i),
  .filt_en_i   (filt_en_i),
  .eop_o       (eop_o),
  .glitch_o    (glitch_o)
);

// File: tb/linestate_eop_detector_tb_top.sv
`timescale 1ns/1ps
module linestate_eop_detector_tb_top;
  localparam logic [1:0] SE0 = 2'b00, JS = 2'b01, KS = 2'b10, SE1 = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ls = JS;
  logic tx = 1'b0, lspd = 1'b0, host = 1'b1, lpm = 1'b0, fen = 1'b1;
  logic eop, glitch;

  int checks = 0, failures = 0;
  int eop_cnt = 0, gl_cnt = 0;
  string cur_tag = "R10";
  logic [1:0] seq[$];

  // reference model state
  logic e_eop = 1'b0, e_gl = 1'b0, m_armed = 1'b0;
  int   m_run = 0;

  always #4 clk = ~clk;

  linestate_eop_detector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .linestate_i(ls), .tx_active_i(tx),
    .low_speed_i(lspd), .host_mode_i(host), .lpm_hs_i(lpm),
    .filt_en_i(fen), .eop_o(eop), .glitch_o(glitch)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_eop <= 1'b0; e_gl <= 1'b0; m_armed <= 1'b0; m_run <= 0;
    end else begin
      bit filt;
      int need;
      filt = fen && (host || (!lspd && lpm));
      need = filt ? 2 : 1;
      if (!tx) begin
        e_eop <= 1'b0; e_gl <= 1'b0; m_run <= 0; m_armed <= 1'b1;
      end else begin
        e_eop <= m_armed && ls == SE0 && (m_run + 1 >= need);
        if (m_armed && ls == SE0 && (m_run + 1 >= need)) m_armed <= 1'b0;
        e_gl  <= m_armed && ls != SE0 && filt && m_run > 0 && m_run < need;
        m_run <= (ls == SE0) ? ((m_run + 1 > 2) ? 2 : m_run + 1) : 0;
      end
    end
  end

  always @(negedge clk) begin
    check(cur_tag, "eop_o", int'(eop), int'(e_eop));
    check(cur_tag, "glitch_o", int'(glitch), int'(e_gl));
    if (eop) eop_cnt++;
    if (glitch) gl_cnt++;
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); tx = 1'b0; ls = JS; end
  endtask

  task automatic run_pkt(input string tag, input int exp_eop, input int exp_gl);
    cur_tag = tag;
    idle(2);
    eop_cnt = 0; gl_cnt = 0;
    foreach (seq[i]) begin @(negedge clk); tx = 1'b1; ls = seq[i]; end
    idle(3);
    check(tag, "eop count", eop_cnt, exp_eop);
    check(tag, "glitch count", gl_cnt, exp_gl);
    seq.delete();
  endtask

  task automatic set_mode(input logic h, input logic s, input logic l, input logic f);
    @(negedge clk); host = h; lspd = s; lpm = l; fen = f;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    check("R10", "eop_o in reset", int'(eop), 0);
    check("R10", "glitch_o in reset", int'(glitch), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R9: host full speed, filter on
    set_mode(1, 0, 0, 1);
    seq = '{JS, KS, SE0, JS, KS, SE0, SE0, JS, JS};
    run_pkt("R1", 1, 1);
    seq = '{KS, SE0, SE0, JS};
    run_pkt("R2", 1, 0);

    // R3 R8: filter off, single SE0 ends, later SE0s ignored
    set_mode(1, 0, 0, 0);
    seq = '{JS, SE0, JS, SE0, SE0, JS};
    run_pkt("R3", 1, 0);

    // R4: host low speed, filter on
    set_mode(1, 1, 0, 1);
    seq = '{KS, SE0, KS, SE0, SE0, KS};
    run_pkt("R4", 1, 1);

    // R5: device variants
    set_mode(0, 0, 0, 1);
    seq = '{JS, SE0, JS};
    run_pkt("R5", 1, 0);
    set_mode(0, 1, 1, 1);
    seq = '{KS, SE0, KS};
    run_pkt("R5", 1, 0);
    set_mode(0, 0, 1, 1);
    seq = '{JS, SE0, JS, SE0, SE0, JS};
    run_pkt("R5", 1, 1);

    // R6: SE1 never ends a packet and breaks a run
    set_mode(1, 0, 0, 1);
    seq = '{SE0, SE1, SE0, SE1, SE1, JS};
    run_pkt("R6", 0, 2);
    set_mode(1, 0, 0, 0);
    seq = '{SE1, SE1, JS};
    run_pkt("R6", 0, 0);

    // R7: SE0 while idle, and run cleared by a dropped tx_active
    set_mode(1, 0, 0, 1);
    cur_tag = "R7";
    eop_cnt = 0; gl_cnt = 0;
    repeat (3) begin @(negedge clk); tx = 1'b0; ls = SE0; end
    @(negedge clk); tx = 1'b1; ls = SE0;
    @(negedge clk); tx = 1'b0; ls = SE0;
    @(negedge clk); tx = 1'b1; ls = SE0;
    @(negedge clk); tx = 1'b1; ls = JS;
    idle(3);
    check("R7", "eop count", eop_cnt, 0);
    check("R7", "glitch count", gl_cnt, 1);

    // R8: once per packet, re-armed after idle
    seq = '{SE0, SE0, JS, SE0, SE0, JS};
    run_pkt("R8", 1, 0);
    seq = '{SE0, SE0, JS};
    run_pkt("R8", 1, 0);

    // R9: glitch in device FS LPM handshake
    set_mode(0, 0, 1, 1);
    seq = '{SE0, JS, SE0, KS, SE0, SE0};
    run_pkt("R9", 1, 2);

    // R10: reset mid-packet, then disarmed until idle seen
    set_mode(1, 0, 0, 0);
    cur_tag = "R10";
    @(negedge clk); tx = 1'b1; ls = JS;
    @(negedge clk); rst_n = 1'b0; #1;
    check("R10", "eop_o async reset", int'(eop), 0);
    check("R10", "glitch_o async reset", int'(glitch), 0);
    @(negedge clk); rst_n = 1'b1;
    eop_cnt = 0;
    @(negedge clk); ls = SE0;
    @(negedge clk); ls = JS;
    @(negedge clk);
    check("R10", "no eop before idle", eop_cnt, 0);
    seq = '{SE0, JS};
    run_pkt("R10", 1, 0);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule